// File: doc/BRIEF.md
# Arcade CPU I/O Register Decoder

This block sits on the bus of an 8-bit-data CPU with a 16-bit address and turns the I/O part of the address space into hardware controls. Writes to a handful of fixed addresses set a sprite bank bit, an NMI enable bit and a screen flip bit. They also drive two coin meter lines and pick a 2 KB ROM bank. A write elsewhere kicks the watchdog. Sound commands reach the sound generator in two steps. A write to one address loads the command byte into a holding latch. A write to a second address then raises a single-cycle strobe that hands the held byte to the sound chip.

Reads are combinational. Six addresses select one of six external input ports: three switch banks, two player controls and a system button port. Every other address reads as all ones. For addresses in the top 2 KB of the CPU space, the block forms a 17-bit physical ROM address from the selected bank. The ROM that answers that address is outside the block. When the `BANKED` parameter is cleared, the bank register and the window mapping are not built.

Top module: `arcade_io_decoder`

## Requirements
- R1: After reset, sprite_bank, nmi_en, flip_out, coin_out, snd_strobe, snd_data and wdog_kick are all zero, and bank 0 is selected.
- R2: A write to 0xE043 stores data bit 3 into sprite_bank from the next cycle on. The other data bits have no visible effect.
- R3: A write to 0xE044 stores data bit 0 into nmi_en and data bit 3 into flip_out from the next cycle on.
- R4: A write to 0xF000 drives coin_out[0] from data bit 0 and coin_out[1] from data bit 1, from the next cycle on.
- R5: The same 0xF000 write stores data bits 7..5 as the ROM bank. Bus addresses 0xF800 to 0xFFFF assert rom_sel and present rom_addr = 0x10000 + bank*0x800 + (bus_addr - 0xF800). Addresses outside that range keep rom_sel low.
- R6: A write into 0xF800 to 0xFFFF changes no register and raises no strobe.
- R7: A write to 0xF200 loads the write data into the sound latch, which appears on snd_data the next cycle, and raises no strobe.
- R8: A write to 0xF400 raises snd_strobe for exactly the next cycle and leaves snd_data at the latched byte. The data written to 0xF400 is ignored.
- R9: A write to 0xF600 raises wdog_kick for exactly the next cycle. No other address raises it.
- R10: rd_data returns port_dip_b at 0xF200, port_dip_c at 0xF400, port_dip_a at 0xF600, port_pad2 at 0xF601, port_pad1 at 0xF602 and port_sys at 0xF603.
- R11: rd_data returns 0xFF for every other address.
- R12: While bus_wr is low, no register changes and no strobe is raised, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write qualifier, sampled on the rising edge |
| rd_data | output | 8 | Combinational read data for bus_addr |
| port_dip_a | input | 8 | Switch bank A (read at 0xF600) |
| port_dip_b | input | 8 | Switch bank B (read at 0xF200) |
| port_dip_c | input | 8 | Switch bank C (read at 0xF400) |
| port_pad1 | input | 8 | Player one controls (read at 0xF602) |
| port_pad2 | input | 8 | Player two controls (read at 0xF601) |
| port_sys | input | 8 | Coin and start buttons (read at 0xF603) |
| rom_sel | output | 1 | bus_addr is inside the banked ROM window |
| rom_addr | output | 17 | Physical ROM address for the window |
| sprite_bank | output | 1 | Sprite RAM bank select |
| nmi_en | output | 1 | NMI enable |
| flip_out | output | 1 | Screen flip |
| coin_out | output | 2 | Coin meter drives |
| snd_data | output | 8 | Latched sound command byte |
| snd_strobe | output | 1 | One-cycle sound write strobe |
| wdog_kick | output | 1 | One-cycle watchdog kick |

## Verification
The hardest case to reach is the separation between loading the sound latch and sending it. The bench has to show that the strobe carries the byte loaded earlier and not the byte written with the send command. For every byte value it therefore writes the value to the load address and then writes its complement to the send address. It checks that the strobe is silent after the load, is high for exactly one cycle after the send, and carries the original byte. It also checks that a write into the ROM window disturbs no register, using a state built up by earlier writes whose bits differ from the data thrown at the window.

// File: rtl/arcade_io_pkg.sv
package arcade_io_pkg;

   localparam logic [15:0] ADR_SPRITE = 16'hE043;
   localparam logic [15:0] ADR_CTRL   = 16'hE044;
   localparam logic [15:0] ADR_COIN   = 16'hF000;
   localparam logic [15:0] ADR_SNDLD  = 16'hF200;
   localparam logic [15:0] ADR_SNDGO  = 16'hF400;
   localparam logic [15:0] ADR_WDOG   = 16'hF600;
   localparam logic [15:0] ADR_PAD2   = 16'hF601;
   localparam logic [15:0] ADR_PAD1   = 16'hF602;
   localparam logic [15:0] ADR_SYS    = 16'hF603;

   typedef struct packed {
      logic spr;
      logic ctl;
      logic coin;
      logic snd_load;
      logic snd_go;
      logic wdog;
   } wr_sel_t;

   typedef enum logic [2:0] {
      RS_NONE = 3'd0,
      RS_DIPB = 3'd1,
      RS_DIPC = 3'd2,
      RS_DIPA = 3'd3,
      RS_PAD2 = 3'd4,
      RS_PAD1 = 3'd5,
      RS_SYS  = 3'd6
   } rd_src_t;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
   import arcade_io_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int WIN_LOG2 = 11,
   parameter logic [15:0] WIN_BASE = 16'hF800
)(
   input  logic [ADDR_W-1:0] addr,
   output wr_sel_t           sel,
   output rd_src_t           src,
   output logic              win_hit
);
   localparam int TAG_W = ADDR_W - WIN_LOG2;

   generate
      if (ADDR_W != 16) begin : g_bad_addr
         $error("io_addr_decode: address width must be 16");
      end
      if (WIN_LOG2 < 1 || WIN_LOG2 >= ADDR_W) begin : g_bad_win
         $error("io_addr_decode: window size out of range");
      end
   endgenerate

   assign win_hit = (addr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1 -: TAG_W]);

   always_comb begin
      sel          = '0;
      sel.spr      = (addr == ADR_SPRITE);
      sel.ctl      = (addr == ADR_CTRL);
      sel.coin     = (addr == ADR_COIN);
      sel.snd_load = (addr == ADR_SNDLD);
      sel.snd_go   = (addr == ADR_SNDGO);
      sel.wdog     = (addr == ADR_WDOG);
   end

   always_comb begin
      unique case (addr)
         ADR_SNDLD: src = RS_DIPB;
         ADR_SNDGO: src = RS_DIPC;
         ADR_WDOG:  src = RS_DIPA;
         ADR_PAD2:  src = RS_PAD2;
         ADR_PAD1:  src = RS_PAD1;
         ADR_SYS:   src = RS_SYS;
         default:   src = RS_NONE;
      endcase
   end

   // R6: no register select may overlap the ROM window
   always_comb begin
      a_r6_window_disjoint: assert (!(win_hit && (sel != '0)));
   end

endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
   import arcade_io_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  rd_src_t           src,
   input  logic [DATA_W-1:0] dip_a,
   input  logic [DATA_W-1:0] dip_b,
   input  logic [DATA_W-1:0] dip_c,
   input  logic [DATA_W-1:0] pad1,
   input  logic [DATA_W-1:0] pad2,
   input  logic [DATA_W-1:0] sys,
   output logic [DATA_W-1:0] rd_data
);
   localparam int N_SLOT = 8;
   localparam logic [DATA_W-1:0] IDLE = {DATA_W{1'b1}};

   logic [DATA_W-1:0] slot [N_SLOT];

   assign slot[RS_NONE] = IDLE;
   assign slot[RS_DIPB] = dip_b;
   assign slot[RS_DIPC] = dip_c;
   assign slot[RS_DIPA] = dip_a;
   assign slot[RS_PAD2] = pad2;
   assign slot[RS_PAD1] = pad1;
   assign slot[RS_SYS]  = sys;
   assign slot[7]       = IDLE;

   assign rd_data = slot[src];

endmodule

// File: rtl/io_ctrl_regs.sv
module io_ctrl_regs
   import arcade_io_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit BANKED   = 1'b1,
   parameter int BANK_W   = 3,
   parameter int BANK_LSB = 5,
   parameter int COIN_N   = 2,
   parameter int SPR_BIT  = 3,
   parameter int NMI_BIT  = 0,
   parameter int FLIP_BIT = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  wr_sel_t           sel,
   input  logic              win_hit,
   output logic              sprite_bank,
   output logic              nmi_en,
   output logic              flip,
   output logic [COIN_N-1:0] coin,
   output logic [BANK_W-1:0] bank,
   output logic [DATA_W-1:0] snd_data,
   output logic              snd_strobe,
   output logic              wdog_kick
);
   generate
      if (BANK_LSB + BANK_W > DATA_W) begin : g_bad_bank
         $error("io_ctrl_regs: bank field exceeds data width");
      end
      if (COIN_N > DATA_W || SPR_BIT >= DATA_W || NMI_BIT >= DATA_W || FLIP_BIT >= DATA_W) begin : g_bad_bits
         $error("io_ctrl_regs: control bit position out of range");
      end
   endgenerate

   wr_sel_t go;
   assign go = wr_en ? sel : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sprite_bank <= 1'b0;
         nmi_en      <= 1'b0;
         flip        <= 1'b0;
         coin        <= '0;
         snd_data    <= '0;
         snd_strobe  <= 1'b0;
         wdog_kick   <= 1'b0;
      end else begin
         if (go.spr)      sprite_bank <= wdata[SPR_BIT];
         if (go.ctl) begin
            nmi_en <= wdata[NMI_BIT];
            flip   <= wdata[FLIP_BIT];
         end
         if (go.coin)     coin     <= wdata[COIN_N-1:0];
         if (go.snd_load) snd_data <= wdata;
         snd_strobe <= go.snd_go;
         wdog_kick  <= go.wdog;
      end
   end

   generate
      if (BANKED) begin : g_bank
         always_ff @(posedge clk) begin
            if (!rst_n)       bank <= '0;
            else if (go.coin) bank <= wdata[BANK_LSB +: BANK_W];
         end
      end else begin : g_nobank
         assign bank = '0;
      end
   endgenerate

   logic [COIN_N+BANK_W+DATA_W+2:0] held;
   assign held = {sprite_bank, nmi_en, flip, coin, bank, snd_data};

   a_r8_send_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel.snd_go) |=> (snd_strobe && $stable(snd_data)));
   a_r7_load_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel.snd_load) |=> (!snd_strobe && snd_data == $past(wdata)));
   a_r9_kick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel.wdog) |=> wdog_kick);
   a_r6_window_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && win_hit) |=> ($stable(held) && !snd_strobe && !wdog_kick));
   a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(held) && !snd_strobe && !wdog_kick));

endmodule

// File: rtl/rom_bank_map.sv
module rom_bank_map #(
   parameter bit BANKED   = 1'b1,
   parameter int ADDR_W   = 16,
   parameter int BANK_W   = 3,
   parameter int WIN_LOG2 = 11,
   parameter int PHYS_W   = 17,
   parameter logic [PHYS_W-1:0] PHYS_BASE = 17'h10000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              win_hit,
   input  logic [BANK_W-1:0] bank,
   output logic              rom_sel,
   output logic [PHYS_W-1:0] rom_addr
);
   localparam longint SPAN = longint'(1) << (BANK_W + WIN_LOG2);

   generate
      if (longint'(PHYS_BASE) + SPAN > (longint'(1) << PHYS_W)) begin : g_bad_phys
         $error("rom_bank_map: banked region does not fit the physical width");
      end

      if (BANKED) begin : g_map
         assign rom_sel  = win_hit;
         assign rom_addr = PHYS_BASE + PHYS_W'({bank, addr[WIN_LOG2-1:0]});
      end else begin : g_flat
         logic unused_map;
         assign unused_map = ^{addr, win_hit, bank};
         assign rom_sel  = 1'b0;
         assign rom_addr = '0;
      end
   endgenerate

   a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel |-> (rom_addr[WIN_LOG2-1:0] == addr[WIN_LOG2-1:0]));
   a_r5_above_base: assert property (@(posedge clk) disable iff (!rst_n)
      rom_sel |-> (rom_addr >= PHYS_BASE));

endmodule

// File: rtl/arcade_io_decoder.sv
module arcade_io_decoder
   import arcade_io_pkg::*;
#(
   parameter bit BANKED   = 1'b1,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int BANK_W   = 3,
   parameter int WIN_LOG2 = 11,
   parameter int PHYS_W   = 17,
   parameter int COIN_N   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] port_dip_a,
   input  logic [DATA_W-1:0] port_dip_b,
   input  logic [DATA_W-1:0] port_dip_c,
   input  logic [DATA_W-1:0] port_pad1,
   input  logic [DATA_W-1:0] port_pad2,
   input  logic [DATA_W-1:0] port_sys,
   output logic              rom_sel,
   output logic [PHYS_W-1:0] rom_addr,
   output logic              sprite_bank,
   output logic              nmi_en,
   output logic              flip_out,
   output logic [COIN_N-1:0] coin_out,
   output logic [DATA_W-1:0] snd_data,
   output logic              snd_strobe,
   output logic              wdog_kick
);
   localparam int BANK_LSB = DATA_W - BANK_W;

   wr_sel_t sel;
   rd_src_t src;
   logic    win_hit;
   logic [BANK_W-1:0] bank;

   io_addr_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
      .addr(bus_addr), .sel(sel), .src(src), .win_hit(win_hit)
   );

   io_read_mux #(.DATA_W(DATA_W)) u_rmux (
      .src(src), .dip_a(port_dip_a), .dip_b(port_dip_b), .dip_c(port_dip_c),
      .pad1(port_pad1), .pad2(port_pad2), .sys(port_sys), .rd_data(rd_data)
   );

   io_ctrl_regs #(
      .DATA_W(DATA_W), .BANKED(BANKED), .BANK_W(BANK_W),
      .BANK_LSB(BANK_LSB), .COIN_N(COIN_N)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wdata(bus_wdata),
      .sel(sel), .win_hit(win_hit),
      .sprite_bank(sprite_bank), .nmi_en(nmi_en), .flip(flip_out),
      .coin(coin_out), .bank(bank), .snd_data(snd_data),
      .snd_strobe(snd_strobe), .wdog_kick(wdog_kick)
   );

   rom_bank_map #(
      .BANKED(BANKED), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
      .WIN_LOG2(WIN_LOG2), .PHYS_W(PHYS_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .win_hit(win_hit),
      .bank(bank), .rom_sel(rom_sel), .rom_addr(rom_addr)
   );

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!snd_strobe && !wdog_kick && !nmi_en && !flip_out && !sprite_bank));
   a_r9_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
      (wdog_kick && !(bus_wr && bus_addr == ADR_WDOG)) |=> !wdog_kick);

endmodule

// File: tb/arcade_io_decoder_bench.sv
module arcade_io_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic [7:0]  bus_wdata = 8'h00;
   logic        bus_wr = 1'b0;
   logic [7:0]  rd_data;
   logic [7:0]  dip_a = 8'h11, dip_b = 8'h22, dip_c = 8'h33;
   logic [7:0]  pad1 = 8'h44, pad2 = 8'h55, sysb = 8'h66;
   logic        rom_sel;
   logic [16:0] rom_addr;
   logic        sprite_bank, nmi_en, flip_out, snd_strobe, wdog_kick;
   logic [1:0]  coin_out;
   logic [7:0]  snd_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   arcade_io_decoder u_arcade_io_decoder (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .rd_data(rd_data),
      .port_dip_a(dip_a), .port_dip_b(dip_b), .port_dip_c(dip_c),
      .port_pad1(pad1), .port_pad2(pad2), .port_sys(sysb),
      .rom_sel(rom_sel), .rom_addr(rom_addr), .sprite_bank(sprite_bank),
      .nmi_en(nmi_en), .flip_out(flip_out), .coin_out(coin_out),
      .snd_data(snd_data), .snd_strobe(snd_strobe), .wdog_kick(wdog_kick)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string req, input [31:0] act, input [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input [15:0] a, input [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic [7:0] exp_rd(input [15:0] a);
      case (a)
         16'hF200: exp_rd = dip_b;
         16'hF400: exp_rd = dip_c;
         16'hF600: exp_rd = dip_a;
         16'hF601: exp_rd = pad2;
         16'hF602: exp_rd = pad1;
         16'hF603: exp_rd = sysb;
         default:  exp_rd = 8'hFF;
      endcase
   endfunction

   function automatic [31:0] state_word();
      state_word = {19'd0, sprite_bank, nmi_en, flip_out, coin_out, snd_data};
   endfunction

   initial begin
      logic [31:0] snap;
      logic [2:0]  bank_m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 state", state_word(), 32'd0);
      check("R1 strobes", {snd_strobe, wdog_kick}, 0);
      bus_addr = 16'hF800; #1;
      check("R1 bank0", rom_addr, 17'h10000);

      // R2 sprite bank sweep
      for (int v = 0; v < 256; v++) begin
         wr(16'hE043, 8'(v));
         check("R2 sprite", sprite_bank, (v >> 3) & 1);
         check("R2 others", {nmi_en, flip_out, coin_out}, 0);
      end

      // R3 control sweep
      for (int v = 0; v < 256; v++) begin
         wr(16'hE044, 8'(v));
         check("R3 nmi", nmi_en, v & 1);
         check("R3 flip", flip_out, (v >> 3) & 1);
         check("R3 sprite kept", sprite_bank, 1);
      end

      // R4/R5 coin and bank sweep
      for (int v = 0; v < 256; v++) begin
         int off;
         wr(16'hF000, 8'(v));
         check("R4 coin", coin_out, v & 3);
         off = (v * 37 + 5) & 'h7FF;
         bus_addr = 16'(16'hF800 + off); #1;
         check("R5 sel", rom_sel, 1);
         check("R5 addr", rom_addr, 32'h10000 + ((v >> 5) * 32'h800) + off);
         bus_addr = 16'hF7FF; #1;
         check("R5 below window", rom_sel, 0);
      end
      bank_m = 3'd7;
      bus_addr = 16'hFFFF; #1;
      check("R5 top", rom_addr, 32'h10000 + bank_m * 32'h800 + 32'h7FF);

      // R6 window writes inert
      wr(16'hE044, 8'h09);
      wr(16'hF000, 8'hA1);
      wr(16'hF200, 8'h5A);
      snap = state_word();
      for (int k = 0; k < 64; k++) begin
         wr(16'(16'hF800 + k * 32), 8'(~k));
         check("R6 state", state_word(), snap);
         check("R6 strobes", {snd_strobe, wdog_kick}, 0);
      end
      bus_addr = 16'hF800; #1;
      check("R6 bank kept", rom_addr, 32'h10000 + 5 * 32'h800);

      // R7/R8 sound latch then send
      for (int v = 0; v < 256; v++) begin
         wr(16'hF200, 8'(v));
         check("R7 no strobe", snd_strobe, 0);
         check("R7 latch", snd_data, v);
         wr(16'hF400, 8'(~v));
         check("R8 strobe", snd_strobe, 1);
         check("R8 data", snd_data, v);
         @(negedge clk);
         check("R8 one cycle", snd_strobe, 0);
      end

      // R9 watchdog kick
      wr(16'hF600, 8'h00);
      check("R9 kick", wdog_kick, 1);
      @(negedge clk);
      check("R9 one cycle", wdog_kick, 0);
      wr(16'hF601, 8'hFF);
      check("R9 neighbour", wdog_kick, 0);
      wr(16'hF400, 8'hFF);
      check("R9 other strobe", wdog_kick, 0);

      // R12 no write enable
      snap = state_word();
      @(negedge clk);
      bus_addr = 16'hE044; bus_wdata = 8'hFF;
      @(negedge clk);
      bus_addr = 16'hF200;
      @(negedge clk);
      bus_addr = 16'hF400;
      @(negedge clk);
      check("R12 state", state_word(), snap);
      check("R12 strobes", {snd_strobe, wdog_kick}, 0);

      // R10/R11 read sweep over several port patterns
      for (int p = 0; p < 4; p++) begin
         dip_a = 8'(p * 17 + 1); dip_b = 8'(p * 29 + 2); dip_c = 8'(p * 41 + 3);
         pad1 = 8'(~(p * 13)); pad2 = 8'(p * 7 + 90); sysb = 8'(p * 61);
         for (int a = 16'hF600; a < 16'hF608; a++) begin
            bus_addr = 16'(a); #1;
            check("R10 port", rd_data, exp_rd(16'(a)));
         end
         bus_addr = 16'hF200; #1;
         check("R10 dip_b", rd_data, dip_b);
         bus_addr = 16'hF400; #1;
         check("R10 dip_c", rd_data, dip_c);
      end
      for (int a = 16'hF000; a < 16'hF800; a++) begin
         bus_addr = 16'(a); #1;
         if (exp_rd(16'(a)) == 8'hFF) check("R11 unmapped", rd_data, 8'hFF);
      end
      for (int a = 16'hE000; a < 16'hE100; a++) begin
         bus_addr = 16'(a); #1;
         check("R11 low io", rd_data, 8'hFF);
      end
      bus_addr = 16'hFC00; #1;
      check("R11 window read", rd_data, 8'hFF);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule